// File: doc/BRIEF.md
# Hex-Record Program Loader

This block turns a stream of ASCII characters, holding hex-format program records one per line, into writes to a program memory. Each record is scanned digit by digit. Its bytes are summed so the checksum can be judged, and its data bytes are paired into 12-bit instruction words. The words leave through a one-word write port, split into six 2-bit lanes so that narrow memory slices can each take their own pair of bits. The load address carried by a record is ignored. Words land at consecutive addresses taken from an internal counter.

After reset the block first sweeps the whole program memory to zero through the same write port. Characters offered during that sweep are dropped. Loading stops for good at the end-of-file record. A one-cycle pulse marks each bad checksum and each malformed record.

Top module: `hexrec_loader`

## Requirements
- R1: After reset, `clr_busy` is high and the block writes zero to every address from 0 to DEPTH-1, one address per cycle in ascending order. `clr_busy` falls together with the last of these writes. A character sampled while `clr_busy` is high has no effect.
- R2: Outside a record, every character other than ':' (0x3A) is ignored, hex digits included. A ':' starts a record.
- R3: Inside a record, hex digits are taken in pairs, most significant nibble first, to form bytes. The bytes are, in order: byte count N, two load-address bytes, record type, N data bytes, checksum. The record ends on its checksum byte.
- R4: If the low 8 bits of the sum of all bytes of a record, checksum included, are not zero, `sum_err` pulses for one cycle at the record's end. Data words of that record are still written.
- R5: Only records of type 0x00 write memory. A record of any other type writes nothing.
- R6: Data bytes pair up in arrival order, first byte low and second byte high. The word is the low 12 bits of low + 256*high. An odd final data byte is written as a word with a zero high byte.
- R7: Data words go to consecutive addresses starting at 0 after reset and continuing across records, whatever load address a record carries. Once DEPTH words have been written, further words are dropped.
- R8: Lane k of `wr_lanes` (bits 2k+1:2k) carries bits 2k+1:2k of the word.
- R9: Digits '0'-'9', 'A'-'F' and 'a'-'f' are accepted as hex digits.
- R10: Any other character inside a record pulses `fmt_err` for one cycle, ends the record without a checksum verdict, and skips the rest of the line up to line feed (0x0A), including any ':' on that line.
- R11: A type 0x01 record with a good checksum pulses `done` for one cycle. After that, no write and no flag occurs until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| char_valid | input | 1 | A character is offered this cycle |
| char_in | input | 8 | ASCII character |
| clr_busy | output | 1 | Zero sweep in progress; characters are dropped |
| wr_en | output | 1 | Memory write strobe |
| wr_addr | output | $clog2(DEPTH) | Memory write address |
| wr_lanes | output | 12 | Word to write, as six 2-bit lanes |
| sum_err | output | 1 | One-cycle pulse: checksum of the finished record was wrong |
| fmt_err | output | 1 | One-cycle pulse: non-hex character inside a record |
| done | output | 1 | One-cycle pulse: end-of-file record accepted |

## Verification
The final zero-sweep write and the first character the host may offer can share a cycle. The bench provokes this in both directions. In one case it offers ':' in the cycle where the second-to-last sweep address is visible: that colon is sampled while the sweep is still busy, so the following record must vanish with no write and no flag. After a fresh reset it offers ':' in the cycle where the last sweep address is visible: that colon is sampled after the sweep has ended, so the record must land at address 0. The bench judges both cases by write counts and by the memory image it rebuilds from observed writes.

// File: rtl/hexrec_pkg.sv
// Shared types and helpers for the hex-record loader.
// Assumes 8-bit ASCII characters.
package hexrec_pkg;

    typedef enum logic [1:0] {
        PS_HUNT = 2'd0,   // waiting for a record mark
        PS_BODY = 2'd1,   // collecting hex digits of a record
        PS_SKIP = 2'd2,   // discarding to end of line after a format error
        PS_HALT = 2'd3    // end-of-file seen, frozen until reset
    } parse_state_t;

    localparam logic [7:0] CH_MARK = 8'h3A;   // ':'
    localparam logic [7:0] CH_LF   = 8'h0A;

    // Returns {is_hex, nibble}
    function automatic logic [4:0] hex_value(input logic [7:0] c);
        logic [7:0] t;
        if (c >= 8'h30 && c <= 8'h39) begin
            t = c - 8'h30;
            return {1'b1, t[3:0]};
        end else if (c >= 8'h41 && c <= 8'h46) begin
            t = c - 8'h37;
            return {1'b1, t[3:0]};
        end else if (c >= 8'h61 && c <= 8'h66) begin
            t = c - 8'h57;
            return {1'b1, t[3:0]};
        end
        return 5'b0_0000;
    endfunction

endpackage

// File: rtl/hexrec_digit.sv
// Combinational ASCII hex digit classifier.
// Assumes: none; purely combinational.
module hexrec_digit
    import hexrec_pkg::*;
(
    input  logic [7:0] ch,
    output logic       is_hex,
    output logic [3:0] nib
);
    logic [4:0] info;

    // classify the character and extract its value
    always_comb begin
        info   = hex_value(ch);
        is_hex = info[4];
        nib    = info[3:0];
    end
endmodule

// File: rtl/hexrec_lanes.sv
// Splits a word into LANES slices of LANE_W bits, slice k taking
// bits (k+1)*LANE_W-1 : k*LANE_W.
// Assumes the word width is exactly LANES*LANE_W.
module hexrec_lanes #(
    parameter int LANES  = 6,
    parameter int LANE_W = 2,
    localparam int WORD_W = LANES * LANE_W
) (
    input  logic [WORD_W-1:0] word_i,
    output logic [WORD_W-1:0] lanes_o
);
    for (genvar k = 0; k < LANES; k++) begin : g_lane
        assign lanes_o[k*LANE_W +: LANE_W] = word_i[k*LANE_W +: LANE_W];
    end
endmodule

// File: rtl/hexrec_parser.sv
// Record parser: finds the record mark, pairs hex digits into bytes,
// accumulates the checksum, and emits data bytes of type-0 records.
// Assumes at most one character per cycle; hold blocks all input.
// Every output is registered and pulses for one cycle.
module hexrec_parser
    import hexrec_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       hold,
    input  logic       char_valid,
    input  logic [7:0] char_in,
    output logic       rec_start,
    output logic       data_stb,
    output logic [7:0] data_byte,
    output logic       data_last,
    output logic       sum_err,
    output logic       fmt_err,
    output logic       done
);
    parse_state_t state;
    logic [9:0]   dig_cnt;
    logic [3:0]   hi_nib;
    logic [7:0]   sum_q;
    logic [7:0]   cnt_q;
    logic [7:0]   type_q;

    logic         is_hex;
    logic [3:0]   nib;
    logic [7:0]   byte_now;
    logic [7:0]   sum_nx;
    logic [8:0]   byte_idx;
    logic [8:0]   end_idx;
    logic [8:0]   last_data_idx;
    logic         take;

    hexrec_digit i_digit (
        .ch     (char_in),
        .is_hex (is_hex),
        .nib    (nib)
    );

    // byte assembly and field positions of the current digit
    always_comb begin
        byte_now      = {hi_nib, nib};
        sum_nx        = sum_q + byte_now;
        byte_idx      = dig_cnt[9:1];
        end_idx       = {1'b0, cnt_q} + 9'd4;
        last_data_idx = {1'b0, cnt_q} + 9'd3;
        take          = char_valid && !hold;
    end

    // record state machine and output pulses
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state     <= PS_HUNT;
            dig_cnt   <= '0;
            hi_nib    <= '0;
            sum_q     <= '0;
            cnt_q     <= '0;
            type_q    <= '0;
            rec_start <= 1'b0;
            data_stb  <= 1'b0;
            data_byte <= '0;
            data_last <= 1'b0;
            sum_err   <= 1'b0;
            fmt_err   <= 1'b0;
            done      <= 1'b0;
        end else begin
            rec_start <= 1'b0;
            data_stb  <= 1'b0;
            data_last <= 1'b0;
            sum_err   <= 1'b0;
            fmt_err   <= 1'b0;
            done      <= 1'b0;
            if (take) begin
                unique case (state)
                    PS_HUNT: begin
                        if (char_in == CH_MARK) begin
                            state     <= PS_BODY;
                            dig_cnt   <= '0;
                            sum_q     <= '0;
                            rec_start <= 1'b1;
                        end
                    end
                    PS_BODY: begin
                        if (!is_hex) begin
                            fmt_err <= 1'b1;
                            state   <= (char_in == CH_LF) ? PS_HUNT : PS_SKIP;
                        end else begin
                            dig_cnt <= dig_cnt + 10'd1;
                            if (!dig_cnt[0]) begin
                                hi_nib <= nib;
                            end else begin
                                sum_q <= sum_nx;
                                if (byte_idx == 9'd0) cnt_q  <= byte_now;
                                if (byte_idx == 9'd3) type_q <= byte_now;
                                if (byte_idx >= 9'd4 && byte_idx < end_idx
                                    && type_q == 8'h00) begin
                                    data_stb  <= 1'b1;
                                    data_byte <= byte_now;
                                    data_last <= (byte_idx == last_data_idx);
                                end
                                if (byte_idx == end_idx) begin
                                    if (sum_nx != 8'h00) begin
                                        sum_err <= 1'b1;
                                        state   <= PS_HUNT;
                                    end else if (type_q == 8'h01) begin
                                        done  <= 1'b1;
                                        state <= PS_HALT;
                                    end else begin
                                        state <= PS_HUNT;
                                    end
                                end
                            end
                        end
                    end
                    PS_SKIP: begin
                        if (char_in == CH_LF) state <= PS_HUNT;
                    end
                    default: ;
                endcase
            end
        end
    end

    // R1: a character sampled during the sweep must never produce a data byte
    AST_HOLD_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
        hold |=> !data_stb);                                        // R1
    // R3: a byte needs two digits, so data strobes are never back to back
    AST_BYTE_GAP: assert property (@(posedge clk) disable iff (!rst_n)
        data_stb |=> !data_stb);                                    // R3
    // R10: at most one record verdict per cycle
    AST_ONE_VERDICT: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({sum_err, fmt_err, done}));                        // R10
    // R11: once frozen, nothing leaves the parser
    AST_HALT_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (state == PS_HALT) |=> !data_stb && !sum_err && !fmt_err);  // R11
endmodule

// File: rtl/hexrec_packer.sv
// Word packer and write-port owner: sweeps memory to zero after reset,
// then pairs data bytes little-endian into words written at a running
// address that saturates at DEPTH.
// Assumes WORD_W <= 16 and data bytes arrive at most every other cycle.
module hexrec_packer #(
    parameter int DEPTH  = 2048,
    parameter int WORD_W = 12,
    localparam int ADDR_W = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rec_start,
    input  logic              data_stb,
    input  logic [7:0]        data_byte,
    input  logic              data_last,
    output logic              clr_busy,
    output logic              wr_en,
    output logic [ADDR_W-1:0] wr_addr,
    output logic [WORD_W-1:0] wr_word
);
    localparam logic [ADDR_W-1:0] LAST_ADDR = ADDR_W'(DEPTH - 1);
    localparam logic [ADDR_W:0]   FULL_CNT  = (ADDR_W + 1)'(DEPTH);

    logic [ADDR_W-1:0] clr_addr;
    logic [ADDR_W:0]   word_cnt;
    logic [7:0]        lo_byte;
    logic              have_lo;
    logic              full;
    logic [15:0]       word16;

    // assemble the candidate word and the full condition
    always_comb begin
        full   = (word_cnt == FULL_CNT);
        word16 = have_lo ? {data_byte, lo_byte} : {8'h00, data_byte};
    end

    // zero sweep, byte pairing and write-port registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            clr_busy <= 1'b1;
            clr_addr <= '0;
            word_cnt <= '0;
            lo_byte  <= '0;
            have_lo  <= 1'b0;
            wr_en    <= 1'b0;
            wr_addr  <= '0;
            wr_word  <= '0;
        end else begin
            wr_en <= 1'b0;
            if (clr_busy) begin
                wr_en    <= 1'b1;
                wr_addr  <= clr_addr;
                wr_word  <= '0;
                clr_addr <= clr_addr + 1'b1;
                if (clr_addr == LAST_ADDR) clr_busy <= 1'b0;
            end else if (rec_start) begin
                have_lo <= 1'b0;
            end else if (data_stb) begin
                if (!have_lo && !data_last) begin
                    lo_byte <= data_byte;
                    have_lo <= 1'b1;
                end else begin
                    have_lo <= 1'b0;
                    if (!full) begin
                        wr_en    <= 1'b1;
                        wr_addr  <= word_cnt[ADDR_W-1:0];
                        wr_word  <= word16[WORD_W-1:0];
                        word_cnt <= word_cnt + 1'b1;
                    end
                end
            end
        end
    end

    // R1: every sweep cycle produces a zero write
    AST_SWEEP_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        clr_busy |=> wr_en && (wr_word == '0));                     // R1
    // R7: once DEPTH words are stored, the port stays silent
    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        full |=> !wr_en);                                           // R7
endmodule

// File: rtl/hexrec_loader.sv
// Top of the hex-record loader: character input, parser, word packer
// and lane fan-out onto a single memory write port.
// Assumes one character per cycle at most.
module hexrec_loader #(
    parameter int DEPTH  = 2048,
    parameter int LANES  = 6,
    parameter int LANE_W = 2,
    localparam int ADDR_W = $clog2(DEPTH),
    localparam int WORD_W = LANES * LANE_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              char_valid,
    input  logic [7:0]        char_in,
    output logic              clr_busy,
    output logic              wr_en,
    output logic [ADDR_W-1:0] wr_addr,
    output logic [WORD_W-1:0] wr_lanes,
    output logic              sum_err,
    output logic              fmt_err,
    output logic              done
);
    logic              rec_start;
    logic              data_stb;
    logic [7:0]        data_byte;
    logic              data_last;
    logic [WORD_W-1:0] wr_word;

    hexrec_parser i_parser (
        .clk        (clk),
        .rst_n      (rst_n),
        .hold       (clr_busy),
        .char_valid (char_valid),
        .char_in    (char_in),
        .rec_start  (rec_start),
        .data_stb   (data_stb),
        .data_byte  (data_byte),
        .data_last  (data_last),
        .sum_err    (sum_err),
        .fmt_err    (fmt_err),
        .done       (done)
    );

    hexrec_packer #(
        .DEPTH  (DEPTH),
        .WORD_W (WORD_W)
    ) i_packer (
        .clk       (clk),
        .rst_n     (rst_n),
        .rec_start (rec_start),
        .data_stb  (data_stb),
        .data_byte (data_byte),
        .data_last (data_last),
        .clr_busy  (clr_busy),
        .wr_en     (wr_en),
        .wr_addr   (wr_addr),
        .wr_word   (wr_word)
    );

    hexrec_lanes #(
        .LANES  (LANES),
        .LANE_W (LANE_W)
    ) i_lanes (
        .word_i  (wr_word),
        .lanes_o (wr_lanes)
    );
endmodule

// File: tb/test_hexrec_loader.sv
`timescale 1ns/1ps
module test_hexrec_loader;
    localparam int DEPTH = 64;
    localparam int AW    = 6;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        char_valid = 1'b0;
    logic [7:0]  char_in = 8'h00;
    logic        clr_busy, wr_en, sum_err, fmt_err, done;
    logic [AW-1:0] wr_addr;
    logic [11:0] wr_lanes;

    hexrec_loader #(.DEPTH(DEPTH)) i_hexrec_loader (
        .clk(clk), .rst_n(rst_n), .char_valid(char_valid), .char_in(char_in),
        .clr_busy(clr_busy), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_lanes(wr_lanes), .sum_err(sum_err), .fmt_err(fmt_err), .done(done)
    );

    always #2 clk = ~clk;   // 250 MHz

    int n_checks = 0, n_fail = 0;
    logic [11:0] dut_mem [DEPTH];
    logic [11:0] exp_mem [DEPTH];
    int exp_addr, exp_wr, exp_sum, exp_fmt, exp_done;
    bit exp_halt;
    int n_wr, n_sum, n_fmt, n_done;
    bit clearing = 1'b1;
    bit finished = 1'b0;

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // observer: 1 ns after each rising edge
    always @(posedge clk) begin
        #1;
        if (rst_n) begin
            if (wr_en) begin
                dut_mem[wr_addr] = wr_lanes;
                if (!clearing) n_wr++;
            end
            if (sum_err) n_sum++;
            if (fmt_err) n_fmt++;
            if (done)    n_done++;
        end
    end

    function automatic logic [7:0] hexc(input int v, input bit lower);
        if (v < 10) return 8'(8'h30 + v);
        return lower ? 8'(8'h57 + v) : 8'(8'h37 + v);
    endfunction

    task automatic send_ch(input logic [7:0] c);
        @(negedge clk);
        char_valid = 1'b1;
        char_in    = c;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            char_valid = 1'b0;
        end
    endtask

    task automatic put_word(input int w);
        if (exp_addr < DEPTH) begin
            exp_mem[exp_addr] = 12'(w);
            exp_addr++;
            exp_wr++;
        end
    endtask

    task automatic send_rec(input int cnt, input int addr, input int typ, input int seed,
                            input bit bad, input bit lower, input bit colon, input bit model);
        logic [7:0] b [0:39];
        int sum = 0;
        b[0] = 8'(cnt); b[1] = 8'(addr >> 8); b[2] = 8'(addr); b[3] = 8'(typ);
        for (int i = 0; i < cnt; i++) b[4+i] = 8'(seed * 37 + i * 11 + 5 + i * i);
        for (int i = 0; i < cnt + 4; i++) sum += b[i];
        b[4+cnt] = 8'((256 - (sum % 256)) % 256) ^ {7'd0, bad};
        if (colon) send_ch(8'h3A);
        for (int i = 0; i < cnt + 5; i++) begin
            send_ch(hexc(b[i] >> 4, lower));
            send_ch(hexc(b[i] & 15, lower));
        end
        send_ch(8'h0D);
        send_ch(8'h0A);
        if (model && !exp_halt) begin
            if (bad) exp_sum++;
            if (typ == 0) begin
                for (int i = 0; i + 1 < cnt; i += 2) put_word((b[4+i] | (b[5+i] << 8)) & 12'hFFF);
                if (cnt % 2 == 1) put_word(b[3+cnt]);
            end
            if (typ == 1 && !bad) begin
                exp_done++;
                exp_halt = 1'b1;
            end
        end
    endtask

    task automatic do_reset(input bit early);
        rst_n = 1'b0; char_valid = 1'b0; clearing = 1'b1;
        repeat (3) @(negedge clk);
        check(clr_busy == 1'b1 && wr_en == 1'b0 && done == 1'b0, "R1 reset state",
              {clr_busy, wr_en, done}, 3'b100);
        for (int a = 0; a < DEPTH; a++) begin
            exp_mem[a] = 12'h000;
            dut_mem[a] = 12'hAAA;
        end
        exp_addr = 0; exp_wr = 0; exp_sum = 0; exp_fmt = 0; exp_done = 0; exp_halt = 0;
        n_wr = 0; n_sum = 0; n_fmt = 0; n_done = 0;
        rst_n = 1'b1;
        for (int i = 0; i < DEPTH; i++) begin
            @(negedge clk);
            char_valid = 1'b0;
            check(wr_en && wr_addr == AW'(i) && wr_lanes == 12'h000, "R1 sweep write",
                  {wr_en, wr_addr, wr_lanes}, {1'b1, AW'(i), 12'h000});
            if (i == DEPTH - 2) check(clr_busy == 1'b1, "R1 busy before end", clr_busy, 1);
            if (i == DEPTH - 1) check(clr_busy == 1'b0, "R1 busy falls", clr_busy, 0);
            if ((early && i == DEPTH - 2) || (!early && i == DEPTH - 1)) begin
                char_valid = 1'b1;
                char_in    = 8'h3A;
            end
        end
        clearing = 1'b0;
    endtask

    task automatic check_phase(input string tag);
        for (int a = 0; a < DEPTH; a++)
            check(dut_mem[a] === exp_mem[a], "R6 R7 R8 stored word", dut_mem[a], exp_mem[a]);
        check(n_wr == exp_wr, "R5 R7 write count", n_wr, exp_wr);
        check(n_sum == exp_sum, "R4 checksum pulses", n_sum, exp_sum);
        check(n_fmt == exp_fmt, "R10 format pulses", n_fmt, exp_fmt);
        check(n_done == exp_done, "R11 done pulses", n_done, exp_done);
        $display("phase %s checked", tag);
    endtask

    initial begin
        // Phase A: colon lost in the sweep, then a mixed record sequence
        do_reset(1'b1);
        send_rec(4, 0, 0, 1, 0, 0, 0, 0);           // R1: body of a dropped record
        idle(4);
        check(n_wr == 0 && n_sum == 0 && n_fmt == 0, "R1 dropped colon",
              n_wr + n_sum + n_fmt, 0);
        send_ch("x"); send_ch("5"); send_ch("F"); send_ch(8'h0A);     // R2
        send_rec(4, 16'h0000, 0, 2, 0, 0, 1, 1);    // R9 upper case, R6 pairs
        send_rec(3, 16'h1234, 0, 3, 0, 1, 1, 1);    // R9 lower case, R6 odd tail, R7 address ignored
        send_rec(6, 16'h0100, 0, 4, 0, 0, 1, 1);    // R7 continues sequentially
        send_rec(2, 16'h0000, 2, 5, 0, 0, 1, 1);    // R5 other type writes nothing
        send_rec(2, 16'h0000, 0, 6, 1, 0, 1, 1);    // R4 bad checksum, data still stored
        send_ch(8'h3A); send_ch("1"); send_ch("0"); send_ch("G");     // R10
        send_ch(8'h3A); send_ch("0"); send_ch("2"); send_ch(8'h0D); send_ch(8'h0A);
        exp_fmt++;
        send_rec(4, 16'h0000, 0, 7, 0, 1, 1, 1);    // R3 parsing resumes after skip
        send_rec(0, 16'h0000, 1, 0, 0, 0, 1, 1);    // R11 end of file
        send_rec(4, 16'h0000, 0, 8, 0, 0, 1, 1);    // R11 ignored after done
        send_rec(2, 16'h0000, 0, 9, 1, 0, 1, 1);    // R11 no flag after done
        idle(6);
        check_phase("A");

        // Phase B: colon right after the sweep, then overfill the memory
        do_reset(1'b0);
        send_rec(2, 16'h0000, 0, 10, 0, 0, 0, 1);   // R1 first idle cycle accepted
        for (int r = 0; r < 9; r++)
            send_rec(16, r * 16, 0, 11 + r, 0, r % 2, 1, 1);    // R7 saturation at DEPTH
        idle(6);
        check(exp_wr == DEPTH, "R7 model reached depth", exp_wr, DEPTH);
        check_phase("B");

        finished = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end

    initial begin
        #(200000 * 4);
        if (!finished) begin
            n_checks++;
            n_fail++;
            $display("FAIL R1 watchdog actual=running expected=finished");
            $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
            $finish;
        end
    end
endmodule